// File: doc/BRIEF.md
# Standby Refresh Clock Controller

This block sits between the clock synthesis core of a two-output clock generator and its output pins, and manages the standby state requested by an active-low power-down input. The memory clock and video clock produced by the synthesizers pass straight through while the input is high. When the input goes low, one of two standby behaviours applies. A single bit in the control word selects which one.

In the refresh standby, the synthesizer enable is removed and the video pin is parked high. The memory pin carries the reference clock divided by an even ratio, so that a DRAM attached to it keeps being refreshed. A 4-bit divisor code held in the block selects that ratio. In the deep standby, the reference oscillator enable and both pin drivers are switched off, and every stored setting is kept for the next wake-up. The divider produces a 50% duty output. It only changes its ratio at the end of a half period, so the memory pin never carries a runt pulse.

Top module: `pdc_power_down_ctrl`

## Requirements
- R1: Reset sets the divisor code to 8 (a ratio of 18) and the standby mode bit to 0, and the outputs pass the synthesizer clocks through.
- R2: While pd_ni was high at the previous reference edge, mclk_o equals mclk_src_i, vclk_o equals vclk_src_i, and both output enables, the synthesizer enable and the oscillator enable are 1.
- R3: In refresh standby (pd_ni low and mode bit 0 at the previous edge), vclk_o is 1, vco_en_o is 0, and osc_en_o and both output enables stay 1.
- R4: In refresh standby, mclk_o is a 50% duty clock whose period in reference cycles is 34 minus twice the divisor code, for codes 1 to 15 (32 down to 4). It starts low for one half period after entry.
- R5: Divisor code 0 gives a period of 32 reference cycles, so the memory pin never stalls.
- R6: A new divisor code takes effect only when the current half period ends. The half period that is running finishes with the old length.
- R7: In deep standby (pd_ni low and mode bit 1 at the previous edge), osc_en_o, vco_en_o, mclk_oe_o and vclk_oe_o are 0, and mclk_o and vclk_o are driven 0.
- R8: The divisor code and the mode bit keep their values through deep standby and reset-free wake-up.
- R9: The mode bit is loaded from bit 21 of the 22-bit control word when ctrl_we_i is high. The other 21 bits have no effect on the outputs.
- R10: A change on pd_ni sampled at a reference edge changes the output selection right after that edge, both on entry to standby and on exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down request, active low |
| div_we_i | input | 1 | Load strobe for the divisor code |
| div_code_i | input | 4 | New divisor code |
| ctrl_we_i | input | 1 | Load strobe for the control word |
| ctrl_word_i | input | 22 | Control word; bit 21 is the standby mode bit |
| mclk_src_i | input | 1 | Memory clock from its synthesizer |
| vclk_src_i | input | 1 | Video clock from its synthesizer |
| mclk_o | output | 1 | Memory clock to the pin |
| vclk_o | output | 1 | Video clock to the pin |
| mclk_oe_o | output | 1 | Memory pin driver enable |
| vclk_oe_o | output | 1 | Video pin driver enable |
| vco_en_o | output | 1 | Synthesizer enable |
| osc_en_o | output | 1 | Reference oscillator enable |

## Verification
The bench writes a new divisor code right after a toggle and checks that the next edge still comes after the old half period. A design that loaded the code at once would cut that half period short and produce a runt pulse. Code 0 and the two extremes, 1 and 15, are measured as whole periods. A decode that left code 0 as zero would freeze the memory pin, and one that was off by one step would come out 2 cycles wrong.

The bench enters deep standby, leaves it, and enters refresh standby again to expose a design that lost its settings while asleep. It also writes a control word whose low bits are all ones and whose bit 21 is clear, which catches a mode bit decoded from the wrong position. The exact edge at which the pins switch on entry and exit is compared every cycle, so an extra or missing register stage shows up immediately.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    PDS_RUN     = 2'd0,
    PDS_REFRESH = 2'd1,
    PDS_HALT    = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs #(
  parameter int CODE_W   = 4,
  parameter int CTRL_W   = 22,
  parameter int MODE_BIT = 21,
  parameter int RST_CODE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              mode_o
);
  localparam logic [CTRL_W-1:0] MODE_MASK = CTRL_W'(1) << MODE_BIT;

  // remaining control bits belong to other blocks
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^(ctrl_word_i & ~MODE_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= CODE_W'(RST_CODE);
      mode_o <= 1'b0;
    end else begin
      if (div_we_i)  code_o <= div_code_i;
      if (ctrl_we_i) mode_o <= ctrl_word_i[MODE_BIT];
    end
  end
endmodule

// File: rtl/pdc_state_ctrl.sv
module pdc_state_ctrl
  import pdc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_ni,
  input  logic      mode_i,
  output pd_state_e state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= PDS_RUN;
    else if (pd_ni)  state_o <= PDS_RUN;
    else if (mode_i) state_o <= PDS_HALT;
    else             state_o <= PDS_REFRESH;
  end
endmodule

// File: rtl/pdc_ref_divider.sv
module pdc_ref_divider #(
  parameter int CODE_W   = 4,
  parameter int MAX_DIV  = 32,
  parameter int DIV_STEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_o
);
  localparam int HALF_MAX = MAX_DIV / 2;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);

  function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] c);
    int h;
    if (c == '0) h = HALF_MAX;
    else         h = (MAX_DIV + DIV_STEP) / 2 - int'(c) * (DIV_STEP / 2);
    return HALF_W'(h);
  endfunction

  logic [HALF_W-1:0] cnt_q, half_q;
  logic              term;

  assign term = (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= half_of(CODE_W'(0));
      div_o  <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      half_q <= half_of(code_i);
      div_o  <= 1'b0;
    end else if (term) begin
      // ratio reloads only at a half-period boundary
      cnt_q  <= '0;
      half_q <= half_of(code_i);
      div_o  <= ~div_o;
    end else begin
      cnt_q  <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/pdc_out_mux.sv
module pdc_out_mux
  import pdc_pkg::*;
(
  input  pd_state_e state_i,
  input  logic      mclk_src_i,
  input  logic      vclk_src_i,
  input  logic      div_i,
  output logic      mclk_o,
  output logic      vclk_o,
  output logic      mclk_oe_o,
  output logic      vclk_oe_o,
  output logic      vco_en_o,
  output logic      osc_en_o
);
  always_comb begin
    mclk_o    = 1'b0;
    vclk_o    = 1'b0;
    mclk_oe_o = 1'b0;
    vclk_oe_o = 1'b0;
    vco_en_o  = 1'b0;
    osc_en_o  = 1'b0;
    unique case (state_i)
      PDS_RUN: begin
        mclk_o    = mclk_src_i;
        vclk_o    = vclk_src_i;
        mclk_oe_o = 1'b1;
        vclk_oe_o = 1'b1;
        vco_en_o  = 1'b1;
        osc_en_o  = 1'b1;
      end
      PDS_REFRESH: begin
        mclk_o    = div_i;
        vclk_o    = 1'b1;
        mclk_oe_o = 1'b1;
        vclk_oe_o = 1'b1;
        osc_en_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pdc_power_down_ctrl.sv
module pdc_power_down_ctrl
  import pdc_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int CTRL_W   = 22,
  parameter int MODE_BIT = 21,
  parameter int MAX_DIV  = 32,
  parameter int DIV_STEP = 2,
  parameter int RST_CODE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              div_we_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic              mclk_src_i,
  input  logic              vclk_src_i,
  output logic              mclk_o,
  output logic              vclk_o,
  output logic              mclk_oe_o,
  output logic              vclk_oe_o,
  output logic              vco_en_o,
  output logic              osc_en_o
);
  logic [CODE_W-1:0] code_q;
  logic              mode_q;
  logic              div_clk;
  pd_state_e         state_q;

  pdc_cfg_regs #(
    .CODE_W(CODE_W), .CTRL_W(CTRL_W), .MODE_BIT(MODE_BIT), .RST_CODE(RST_CODE)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .div_we_i(div_we_i), .div_code_i(div_code_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_word_i(ctrl_word_i),
    .code_o(code_q), .mode_o(mode_q)
  );

  pdc_state_ctrl i_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .mode_i(mode_q), .state_o(state_q)
  );

  pdc_ref_divider #(
    .CODE_W(CODE_W), .MAX_DIV(MAX_DIV), .DIV_STEP(DIV_STEP)
  ) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(state_q == PDS_REFRESH), .code_i(code_q), .div_o(div_clk)
  );

  pdc_out_mux i_mux (
    .state_i(state_q), .mclk_src_i(mclk_src_i), .vclk_src_i(vclk_src_i), .div_i(div_clk),
    .mclk_o(mclk_o), .vclk_o(vclk_o), .mclk_oe_o(mclk_oe_o), .vclk_oe_o(vclk_oe_o),
    .vco_en_o(vco_en_o), .osc_en_o(osc_en_o)
  );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int HALF_MAX = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_ni,
  input logic mode_i,
  input logic mclk_src_i,
  input logic vclk_src_i,
  input logic mclk_o,
  input logic vclk_o,
  input logic mclk_oe_o,
  input logic vclk_oe_o,
  input logic vco_en_o,
  input logic osc_en_o
);
  localparam int RUN_W = $clog2(HALF_MAX + 3) + 1;

  logic             armed, pd_d, mode_d, mclk_d;
  logic [RUN_W-1:0] run_q;
  logic             refresh_now;

  assign refresh_now = armed && !pd_d && !mode_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed  <= 1'b0;
      pd_d   <= 1'b1;
      mode_d <= 1'b0;
      mclk_d <= 1'b0;
      run_q  <= '0;
    end else begin
      armed  <= 1'b1;
      pd_d   <= pd_ni;
      mode_d <= mode_i;
      mclk_d <= mclk_o;
      if (!refresh_now)                 run_q <= '0;
      else if (mclk_o != mclk_d)        run_q <= RUN_W'(1);
      else if (run_q != '1)             run_q <= run_q + RUN_W'(1);
    end
  end

  assert_normal_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(pd_ni)) |-> (mclk_o == mclk_src_i && vclk_o == vclk_src_i &&
      mclk_oe_o && vclk_oe_o && vco_en_o && osc_en_o));

  assert_refresh_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(pd_ni) && !$past(mode_i)) |->
      (vclk_o && !vco_en_o && osc_en_o && mclk_oe_o && vclk_oe_o));

  assert_deep_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(pd_ni) && $past(mode_i)) |->
      (!osc_en_o && !vco_en_o && !mclk_oe_o && !vclk_oe_o && !mclk_o && !vclk_o));

  assert_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_now |-> (run_q <= RUN_W'(HALF_MAX + 1)));
endmodule

bind pdc_power_down_ctrl pdc_checker #(.HALF_MAX(MAX_DIV / 2)) i_pdc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .mode_i(mode_q),
  .mclk_src_i(mclk_src_i), .vclk_src_i(vclk_src_i),
  .mclk_o(mclk_o), .vclk_o(vclk_o), .mclk_oe_o(mclk_oe_o), .vclk_oe_o(vclk_oe_o),
  .vco_en_o(vco_en_o), .osc_en_o(osc_en_o)
);

// File: tb/test_pdc_power_down_ctrl.sv
`timescale 1ns/1ps
module test_pdc_power_down_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_n = 1'b1;
  logic        div_we = 1'b0;
  logic [3:0]  div_code = 4'd0;
  logic        ctrl_we = 1'b0;
  logic [21:0] ctrl_word = '0;
  logic        mclk_src = 1'b0, vclk_src = 1'b0;
  logic        mclk, vclk, mclk_oe, vclk_oe, vco_en, osc_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  pdc_power_down_ctrl i_pdc_power_down_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n),
    .div_we_i(div_we), .div_code_i(div_code),
    .ctrl_we_i(ctrl_we), .ctrl_word_i(ctrl_word),
    .mclk_src_i(mclk_src), .vclk_src_i(vclk_src),
    .mclk_o(mclk), .vclk_o(vclk), .mclk_oe_o(mclk_oe), .vclk_oe_o(vclk_oe),
    .vco_en_o(vco_en), .osc_en_o(osc_en)
  );

  // behavioural reference model
  int m_code, m_mode, m_state, m_lvl, m_left;

  function automatic int half_len(int c);
    return (c == 0) ? 16 : 17 - c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 8; m_mode = 0; m_state = 0; m_lvl = 0; m_left = half_len(8);
    end else begin
      int oc, om, os;
      oc = m_code; om = m_mode; os = m_state;
      if (os == 1) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_lvl = 1 - m_lvl;
          m_left = half_len(oc);
        end
      end else begin
        m_lvl = 0;
        m_left = half_len(oc);
      end
      m_state = pd_n ? 0 : (om != 0 ? 2 : 1);
      if (div_we)  m_code = int'(div_code);
      if (ctrl_we) m_mode = int'(ctrl_word[21]);
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  task automatic compare;
    logic [5:0] act, exp;
    string rq;
    act = {mclk, vclk, mclk_oe, vclk_oe, vco_en, osc_en};
    case (m_state)
      0: begin exp = {mclk_src, vclk_src, 4'b1111}; rq = "R2"; end
      1: begin exp = {m_lvl[0], 1'b1, 4'b1101}; rq = "R3 R4"; end
      default: begin exp = 6'b000000; rq = "R7"; end
    endcase
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): pins actual %b expected %b", tag, rq, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #4;
    compare();
    mclk_src = ~mclk_src;
    vclk_src = cyc[2] ^ cyc[0];
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_div(input int c);
    div_code = 4'(c); div_we = 1'b1;
    step();
    div_we = 1'b0;
  endtask

  task automatic write_ctrl(input logic [21:0] w);
    ctrl_word = w; ctrl_we = 1'b1;
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic check_val(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // steps until mclk shows the given level after the opposite one
  task automatic wait_edge(input logic lvl, output int n);
    logic prev;
    prev = mclk;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      n++;
      if (prev == ~lvl && mclk == lvl) break;
      prev = mclk;
    end
  endtask

  task automatic measure(input string rq, input int exp);
    int n;
    wait_edge(1'b1, n);
    wait_edge(1'b1, n);
    check_val(rq, n, exp);
  endtask

  initial begin
    int n;
    #35 rst_n = 1'b1;
    tag = "R1";
    steps(3);
    tag = "R2";
    steps(20);
    // default code 8 and default mode 0 give refresh standby, ratio 18
    tag = "R10"; pd_n = 1'b0;
    step();
    tag = "R1";
    measure("R1", 18);
    tag = "R4";
    write_div(15); measure("R4", 4);
    write_div(1);  measure("R4", 32);
    write_div(5);  measure("R4", 24);
    tag = "R5";
    write_div(0);  measure("R5", 32);
    // mid-period change keeps the running half period
    tag = "R6";
    write_div(15); measure("R6", 4);
    wait_edge(1'b1, n);
    write_div(1);
    wait_edge(1'b0, n);
    check_val("R6", n + 1, 2);
    wait_edge(1'b1, n);
    check_val("R6", n, 16);
    // exit and re-entry edge timing
    tag = "R10"; pd_n = 1'b1; steps(5);
    pd_n = 1'b0; steps(3);
    pd_n = 1'b1; steps(3);
    // deep standby
    tag = "R7";
    write_div(5);
    write_ctrl(22'h200000);
    pd_n = 1'b0; steps(30);
    tag = "R10"; pd_n = 1'b1; steps(4);
    // settings kept across deep standby
    tag = "R9";
    write_ctrl(22'h1FFFFF);
    pd_n = 1'b0; step();
    check_val("R9", int'(vclk), 1);
    tag = "R8";
    measure("R8", 24);
    pd_n = 1'b1; steps(4);
    tag = "R9";
    write_ctrl(22'h3FFFFF);
    pd_n = 1'b0; steps(4);
    check_val("R9", int'(osc_en), 0);
    pd_n = 1'b1; steps(4);
    report();
    $finish;
  end
endmodule